// File: doc/BRIEF.md
# Sequential 32/16 Integer Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder on two separate ports. The operands may be treated as signed or unsigned. The 32-bit dividend arrives as a high word and a low word. In 16-bit mode the low word alone is the dividend. It is zero-extended for unsigned division and sign-extended for signed division, and the high word is not used.

The divider works one bit at a time with a restoring shift-subtract loop. Every operation runs exactly 16 iterations, one per divisor bit, so all four variants take the same time. Signed operands are first converted to magnitudes. The signs are applied again after the loop: the quotient is truncated toward zero and the remainder takes the sign of the dividend. A zero divisor raises `div_zero`. A quotient that does not fit in 16 bits raises `overflow`.

The control is a four-state machine:
- `ST_IDLE`: waiting. It moves to `ST_ITER` when `start` is seen.
- `ST_ITER`: runs the 16 iterations. It moves to `ST_FIX` when the iteration counter reaches its last value.
- `ST_FIX`: applies the signs, forms the flags and registers the results. It always moves to `ST_DONE`.
- `ST_DONE`: raises `done` for one cycle. It moves to `ST_ITER` if `start` is high, and otherwise to `ST_IDLE`.

Top module: `int_divider`

## Requirements
- R1: A `start` sampled high while `busy` is low is accepted. `busy` is then high for exactly 17 cycles. In the cycle after `busy` falls, `done` is high for exactly one cycle, and `busy` is low while `done` is high.
- R2: The latency from acceptance to `done` is the same for signed and unsigned division, for 32-bit and 16-bit dividends, and for divide-by-zero and overflow cases.
- R3: A `start` sampled while `busy` is high is ignored. The running operation completes on time with results from the operands it latched.
- R4: Unsigned 32-bit mode (`wide`=1, `is_signed`=0) gives quotient = floor({dividend_hi,dividend_lo} / divisor) and remainder = {dividend_hi,dividend_lo} mod divisor.
- R5: Unsigned 16-bit mode (`wide`=0, `is_signed`=0) divides the zero-extended `dividend_lo`. `dividend_hi` has no effect on any output.
- R6: Signed 32-bit mode (`wide`=1, `is_signed`=1) treats both operands as two's complement. The quotient is truncated toward zero, and the remainder is either zero or has the sign of the dividend.
- R7: Signed 16-bit mode (`wide`=0, `is_signed`=1) sign-extends `dividend_lo` from bit 15. `dividend_hi` has no effect on any output.
- R8: When the divisor is zero, the results are `div_zero`=1, `overflow`=0, quotient = 16'hFFFF and remainder = `dividend_lo`.
- R9: When the divisor is non-zero and the true quotient lies outside 0..65535 (unsigned) or -32768..32767 (signed), the results are `overflow`=1 and `div_zero`=0. Quotient and remainder are then unspecified. Otherwise `overflow` is 0.
- R10: Quotient, remainder, `div_zero` and `overflow` change only in the cycle in which `done` rises, and hold their values at all other times.
- R11: After reset, `busy` and `done` are 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; accepted only while `busy` is low |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| wide | input | 1 | 1 = 32-bit dividend {hi,lo}, 0 = 16-bit dividend (lo) |
| dividend_hi | input | 16 | Upper word of the 32-bit dividend |
| dividend_lo | input | 16 | Lower word of the dividend |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient |
| remainder | output | 16 | Remainder |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient did not fit in 16 bits |

## Verification
The hardest cases to reach are at the signed edges. These are a most-negative dividend or divisor, whose magnitude only just fits its unsigned width, and quotients that sit exactly at +32767, -32768 or one step beyond. Neither random operands nor small values reach them. The stimulus therefore sweeps a grid of operand words built around 0, ±1, 0x7FFF, 0x8000, 0x8001 and 0xFFFF. The grid is applied in every mode, and in 32-bit mode it is combined with high words on both sides of the divisor, so the overflow boundary is crossed in both directions. A second `start` during the iterations, and fresh operands presented after `done`, show at the ports that running and finished results are left alone.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ITER,
        ST_FIX,
        ST_DONE
    } div_state_e;

endpackage

// File: rtl/div_operand_prep.sv
// Forms the unsigned magnitudes that the iteration loop works on, together
// with the operand signs and the early overflow test for the high half.
module div_operand_prep #(
    parameter int W = 16
) (
    input  logic           is_signed,
    input  logic           wide,
    input  logic [W-1:0]   num_hi,
    input  logic [W-1:0]   num_lo,
    input  logic [W-1:0]   den,
    output logic [2*W-1:0] num_mag,
    output logic [W-1:0]   den_mag,
    output logic           num_neg,
    output logic           den_neg,
    output logic           den_zero,
    output logic           hi_overflow
);
    localparam int DW = 2 * W;

    logic [DW-1:0] num_ext;

    always_comb begin
        if (wide) begin
            num_ext = {num_hi, num_lo};
        end else if (is_signed) begin
            num_ext = {{W{num_lo[W-1]}}, num_lo};
        end else begin
            num_ext = {{W{1'b0}}, num_lo};
        end
        num_neg     = is_signed & num_ext[DW-1];
        den_neg     = is_signed & den[W-1];
        num_mag     = num_neg ? (~num_ext + DW'(1)) : num_ext;
        den_mag     = den_neg ? (~den + W'(1)) : den;
        den_zero    = (den == '0);
        // The upper half of the magnitude must stay below the divisor,
        // or the quotient will not fit in W bits.
        hi_overflow = (num_mag[DW-1:W] >= den_mag);
    end

endmodule

// File: rtl/div_step.sv
// One restoring shift-subtract iteration.
module div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] den,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        trial   = {rem_in, quo_in[W-1]};
        fits    = (trial >= {1'b0, den});
        diff    = trial - {1'b0, den};
        rem_out = fits ? diff[W-1:0] : trial[W-1:0];
        quo_out = {quo_in[W-2:0], fits};
    end

endmodule

// File: rtl/div_result_fix.sv
// Applies the signs to the magnitudes and forms the error flags.
module div_result_fix #(
    parameter int W = 16
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         quo_neg,
    input  logic         rem_neg,
    input  logic         is_signed,
    input  logic         hi_overflow,
    input  logic         den_zero,
    input  logic [W-1:0] num_lo,
    output logic [W-1:0] quo_res,
    output logic [W-1:0] rem_res,
    output logic         zero_flag,
    output logic         ovf_flag
);
    localparam logic [W-1:0] HALF = W'(1) << (W - 1);

    logic signed_limit;

    always_comb begin
        // The negative range reaches one step further than the positive one.
        signed_limit = quo_neg ? (quo_mag > HALF) : quo_mag[W-1];
        zero_flag    = den_zero;
        ovf_flag     = !den_zero && (hi_overflow || (is_signed && signed_limit));
        if (den_zero) begin
            quo_res = '1;
            rem_res = num_lo;
        end else begin
            quo_res = quo_neg ? (~quo_mag + W'(1)) : quo_mag;
            rem_res = rem_neg ? (~rem_mag + W'(1)) : rem_mag;
        end
    end

endmodule

// File: rtl/int_divider.sv
module int_divider
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic         wide,
    input  logic [W-1:0] dividend_hi,
    input  logic [W-1:0] dividend_lo,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_zero,
    output logic         overflow
);
    localparam int             CW   = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0]  LAST = CW'(W - 1);

    div_state_e    state_q, state_d;
    logic [CW-1:0] iter_q;
    logic          accept;

    // Operand prep outputs.
    logic [2*W-1:0] num_mag;
    logic [W-1:0]   den_mag;
    logic           num_neg, den_neg, den_zero, hi_ovf;

    // Iteration state.
    logic [W-1:0] rem_q, quo_q, den_q, lo_q;
    logic         qneg_q, rneg_q, sgn_q, hiovf_q, dz_q;
    logic [W-1:0] rem_n, quo_n;

    // Fix-up outputs.
    logic [W-1:0] quo_fix, rem_fix;
    logic         zero_fix, ovf_fix;

    div_operand_prep #(.W(W)) u_prep (
        .is_signed   (is_signed),
        .wide        (wide),
        .num_hi      (dividend_hi),
        .num_lo      (dividend_lo),
        .den         (divisor),
        .num_mag     (num_mag),
        .den_mag     (den_mag),
        .num_neg     (num_neg),
        .den_neg     (den_neg),
        .den_zero    (den_zero),
        .hi_overflow (hi_ovf)
    );

    div_step #(.W(W)) u_step (
        .rem_in  (rem_q),
        .quo_in  (quo_q),
        .den     (den_q),
        .rem_out (rem_n),
        .quo_out (quo_n)
    );

    div_result_fix #(.W(W)) u_fix (
        .quo_mag     (quo_q),
        .rem_mag     (rem_q),
        .quo_neg     (qneg_q),
        .rem_neg     (rneg_q),
        .is_signed   (sgn_q),
        .hi_overflow (hiovf_q),
        .den_zero    (dz_q),
        .num_lo      (lo_q),
        .quo_res     (quo_fix),
        .rem_res     (rem_fix),
        .zero_flag   (zero_fix),
        .ovf_flag    (ovf_fix)
    );

    // Output decode.
    always_comb begin
        busy   = (state_q == ST_ITER) || (state_q == ST_FIX);
        done   = (state_q == ST_DONE);
        accept = start && !busy;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_ITER;
            ST_ITER: if (iter_q == LAST) state_d = ST_FIX;
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_ITER : ST_IDLE;
        endcase
    end

    // State register and iteration counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                iter_q <= '0;
            end else if (state_q == ST_ITER) begin
                iter_q <= iter_q + CW'(1);
            end
        end
    end

    // Operand capture and iteration datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quo_q   <= '0;
            den_q   <= '0;
            lo_q    <= '0;
            qneg_q  <= 1'b0;
            rneg_q  <= 1'b0;
            sgn_q   <= 1'b0;
            hiovf_q <= 1'b0;
            dz_q    <= 1'b0;
        end else if (accept) begin
            rem_q   <= num_mag[2*W-1:W];
            quo_q   <= num_mag[W-1:0];
            den_q   <= den_mag;
            lo_q    <= dividend_lo;
            qneg_q  <= num_neg ^ den_neg;
            rneg_q  <= num_neg;
            sgn_q   <= is_signed;
            hiovf_q <= hi_ovf;
            dz_q    <= den_zero;
        end else if (state_q == ST_ITER) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
        end
    end

    // Result registers, loaded once per operation.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quotient  <= '0;
            remainder <= '0;
            div_zero  <= 1'b0;
            overflow  <= 1'b0;
        end else if (state_q == ST_FIX) begin
            quotient  <= quo_fix;
            remainder <= rem_fix;
            div_zero  <= zero_fix;
            overflow  <= ovf_fix;
        end
    end

endmodule

// File: rtl/int_divider_chk.sv
module int_divider_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         div_zero,
    input logic         overflow
);
    logic [7:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 8'd1;
        end else begin
            busy_run <= '0;
        end
    end

    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r1_busy_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r2_fixed_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == 8'(W + 1)));

    a_r3_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    a_r8_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (!overflow && quotient == '1));

    a_r10_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || ($stable(quotient) && $stable(remainder)
                            && $stable(div_zero) && $stable(overflow))));

endmodule

bind int_divider int_divider_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .div_zero  (div_zero),
    .overflow  (overflow)
);

// File: tb/int_divider_test.sv
module int_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic        wide = 1'b0;
    logic [15:0] dividend_hi = '0;
    logic [15:0] dividend_lo = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, div_zero, overflow;
    logic [15:0] quotient, remainder;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    int_divider #(.W(16)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .wide(wide), .dividend_hi(dividend_hi), .dividend_lo(dividend_lo),
        .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .div_zero(div_zero), .overflow(overflow)
    );

    logic [15:0] pats [16] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
                               16'h0007, 16'h00FF, 16'h0100, 16'h1234,
                               16'h7FFE, 16'h7FFF, 16'h8000, 16'h8001,
                               16'hA5A5, 16'hFF00, 16'hFFFE, 16'hFFFF};
    logic [15:0] lows [4] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF};

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] hi, input logic [15:0] lo,
                       input logic [15:0] dv, input logic sg, input logic wd,
                       input bit poke);
        longint n, d, q, r;
        bit     ovf;
        int     lat;
        string  tag;
        if (wd) n = sg ? longint'($signed({hi, lo})) : longint'({hi, lo});
        else    n = sg ? longint'($signed(lo)) : longint'(lo);
        d = sg ? longint'($signed(dv)) : longint'(dv);
        ovf = 1'b0;
        q = 0;
        r = 0;
        if (d != 0) begin
            q = n / d;
            r = n % d;
            ovf = sg ? (q < -32768 || q > 32767) : (q > 65535);
        end
        if (d == 0)          tag = "R8";
        else if (ovf)        tag = "R9";
        else if (wd && sg)   tag = "R6";
        else if (wd)         tag = "R4";
        else if (sg)         tag = "R7";
        else                 tag = "R5";

        @(negedge clk);
        dividend_hi = hi; dividend_lo = lo; divisor = dv;
        is_signed = sg; wide = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (1) begin
            if (poke && lat == 3) begin
                start = 1'b1; dividend_lo = ~lo; divisor = dv + 16'd1;
                dividend_hi = ~hi; is_signed = ~sg; wide = ~wd;
            end else if (poke && lat == 4) begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
            if (done || lat > 100) break;
        end
        chk(poke ? "R3" : (d == 0 || ovf) ? "R2" : "R1", "latency",
            longint'(lat), 17);
        if (d == 0) begin
            chk(tag, "div_zero", longint'(div_zero), 1);
            chk(tag, "overflow", longint'(overflow), 0);
            chk(tag, "quotient", longint'(quotient), 64'hFFFF);
            chk(tag, "remainder", longint'(remainder), longint'(lo));
        end else if (ovf) begin
            chk(tag, "overflow", longint'(overflow), 1);
            chk(tag, "div_zero", longint'(div_zero), 0);
        end else begin
            chk(poke ? "R3" : tag, "result",
                longint'({div_zero, overflow, quotient, remainder}),
                longint'({2'b00, q[15:0], r[15:0]}));
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        wait (cyc >= 190000);
        nfail++;
        $display("FAIL R1 watchdog: cycles %0d expected below %0d", cyc, 190000);
        summary();
        $finish;
    end

    initial begin
        logic [15:0] hq, hr;
        logic        hz, ho;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "busy", longint'(busy), 0);
        chk("R11", "done", longint'(done), 0);
        chk("R11", "outputs", longint'({div_zero, overflow, quotient, remainder}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "idle busy", longint'(busy), 0);

        // R5, R7: 16-bit modes swept over the grid, high word random
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    run(16'($urandom), pats[i], pats[j], m[0], 1'b0, 1'b0);

        // R4, R6, R9: 32-bit modes over high words, low corners and divisors
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 16; i++)
                for (int k = 0; k < 4; k++)
                    for (int j = 0; j < 16; j++)
                        run(pats[i], lows[k], pats[j], m[0], 1'b1, 1'b0);

        // R4, R6, R9: pseudo-random operands in every mode
        for (int t = 0; t < 1200; t++) begin
            logic [15:0] dv;
            dv = 16'($urandom);
            run((t % 3 == 0) ? 16'($urandom) : 16'($urandom) % (dv | 16'd1) >> 1,
                16'($urandom), dv, t[0], t[1], 1'b0);
        end

        // R3: start during the iterations is ignored
        run(16'h0012, 16'h3456, 16'h0789, 1'b0, 1'b1, 1'b1);
        run(16'hFFFF, 16'h8000, 16'h0003, 1'b1, 1'b1, 1'b1);

        // R10: results hold while inputs change after done
        run(16'h0000, 16'h0064, 16'h0007, 1'b0, 1'b0, 1'b0);
        hq = quotient; hr = remainder; hz = div_zero; ho = overflow;
        @(negedge clk);
        dividend_lo = 16'hBEEF; divisor = 16'h0000; is_signed = 1'b1; wide = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10", "held", longint'({div_zero, overflow, quotient, remainder}),
            longint'({hz, ho, hq, hr}));
        chk("R10", "quotient value", longint'(quotient), 14);

        summary();
        $finish;
    end

endmodule